// File: doc/BRIEF.md
# Piecewise-Linear Phase Index Generator

The block turns a stream of time-multiplexed samples into a stream of phase table indices. Channels arrive one after another, one channel per valid sample. Each channel has its own starting phase (the offset) and its own phase increment per sample (the step). Each channel also keeps its own running sum of steps. For every valid sample the block produces `(offset + step * t) mod 2^OFS_W`, where `t` counts that channel's samples since the last sync pulse. A later sine/cosine table and a mixer use the index; neither is part of this block.

The offset and step coefficients are held in two pages. The datapath reads the active page while the host fills the other one through a simple write port. Every sync pulse swaps the two pages, so coefficients written during one sync interval are used in the next. The sync pulse also clears all channel accumulators and restarts the channel sequence at channel 0.

A two-state controller gates the datapath. It resets into `SEQ_WAIT`, where no coefficient page has yet been put in use and valid samples are dropped. The transition "first sync" moves it to `SEQ_RUN`. It stays in `SEQ_RUN` until reset, and each later sync only restarts the interval.

Top module: `phase_index_gen`

## Requirements
- R1: After reset `idx_valid` is 0, page 0 is the active page and every channel accumulator reads as zero.
- R2: In state `SEQ_WAIT` (from reset until the first sync) a valid sample without sync produces no output and does not advance the channel sequence or any accumulator.
- R3: For each processed sample, one cycle later `idx_valid` is 1, `idx_chan` holds the sample's channel, and `idx_value` = (offset[ch] + accumulator[ch] bits [ACC_W-1 : ACC_W-OFS_W]) mod 2^OFS_W.
- R4: The step is added to a channel's accumulator after that channel's index is formed, so the first sample of a channel in an interval gives the bare offset. The accumulator adds the zero-extended step and wraps modulo 2^ACC_W.
- R5: The channel number is 0 for a sample that arrives together with sync. It advances by one on each processed sample and wraps from NCH-1 to 0. Cycles without a valid sample do not advance it.
- R6: A sync pulse clears every channel accumulator. A valid sample in the sync cycle is t = 0 of channel 0 of the new interval.
- R7: A coefficient write lands in the inactive page and does not change any index until the next sync swaps pages. Each sync toggles the active page.
- R8: `cfg_sel` = 0 writes an offset (the low OFS_W bits of `cfg_data`) and `cfg_sel` = 1 writes a step (the low STEP_W bits), at entry `cfg_addr` = channel number. A write in the same cycle as sync goes to the page that is inactive after that swap.
- R9: In `SEQ_RUN`, a cycle without a valid sample gives `idx_valid` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Single-cycle interval start: swaps pages, clears accumulators, restarts channels |
| smp_valid | input | 1 | A sample for the next channel is present this cycle |
| cfg_wr | input | 1 | Host coefficient write strobe |
| cfg_sel | input | 1 | 0 = offset, 1 = step |
| cfg_addr | input | CH_W | Channel whose coefficient is written |
| cfg_data | input | CFG_W | Coefficient value, low bits used |
| idx_valid | output | 1 | Index output is valid |
| idx_chan | output | CH_W | Channel of the index |
| idx_value | output | OFS_W | Phase table index |

## Verification
The assertions assume that `sync_in` is a single-cycle pulse, that `cfg_addr` is always below NCH, and that reset is applied synchronously before any activity. Under those conditions the page pointer must toggle exactly once per sync, the live-channel set may hold at most one member right after a flush, and the channel counter stays in range. The stimulus raises sync for single cycles only and writes only to channel addresses 0 to NCH-1. It fills every coefficient entry of a page before a sync makes that page active, so no unwritten entry is ever read. A behavioural model in the bench tracks both pages, the per-channel sums and the channel counter, and is compared with the outputs every cycle. It covers long intervals that wrap both the index and the accumulator, sync pulses with and without a coincident sample, and writes that coincide with sync.

// File: rtl/pli_pkg.sv
package pli_pkg;

    typedef enum logic {
        SEQ_WAIT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    localparam logic SEL_OFFSET = 1'b0;
    localparam logic SEL_STEP   = 1'b1;

endpackage

// File: rtl/pli_coef_store.sv
module pli_coef_store #(
    parameter int NCH    = 256,
    parameter int OFS_W  = 10,
    parameter int STEP_W = 17,
    parameter int CFG_W  = 17,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [CH_W-1:0]   wr_addr_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    input  logic [CH_W-1:0]   rd_addr_i,
    output logic [OFS_W-1:0]  rd_ofs_o,
    output logic [STEP_W-1:0] rd_step_o
);
    import pli_pkg::*;

    localparam int NPG = 2;

    logic act_pg;
    logic eff_pg;
    logic wr_pg;

    logic [OFS_W-1:0]  ofs_rd  [NPG];
    logic [STEP_W-1:0] step_rd [NPG];

    // the page in use this cycle already reflects a swap happening now
    assign eff_pg = act_pg ^ swap_i;
    assign wr_pg  = ~eff_pg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pg <= 1'b0;
        end else if (swap_i) begin
            act_pg <= ~act_pg;
        end
    end

    for (genvar p = 0; p < NPG; p++) begin : g_page
        logic [OFS_W-1:0]  ofs_mem  [NCH];
        logic [STEP_W-1:0] step_mem [NCH];
        logic              hit;

        assign hit = wr_en_i && (wr_pg == p[0]) && (int'(wr_addr_i) < NCH);

        always_ff @(posedge clk) begin
            if (hit && wr_sel_i == SEL_OFFSET) begin
                ofs_mem[wr_addr_i] <= wr_data_i[OFS_W-1:0];
            end
            if (hit && wr_sel_i == SEL_STEP) begin
                step_mem[wr_addr_i] <= wr_data_i[STEP_W-1:0];
            end
        end

        assign ofs_rd[p]  = ofs_mem[rd_addr_i];
        assign step_rd[p] = step_mem[rd_addr_i];
    end

    assign rd_ofs_o  = ofs_rd[eff_pg];
    assign rd_step_o = step_rd[eff_pg];

    // R7
    page_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (act_pg != $past(act_pg)));

    // R7
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(act_pg));

endmodule

// File: rtl/pli_chan_seq.sv
module pli_chan_seq #(
    parameter int NCH  = 256,
    parameter int CH_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_i,
    input  logic                valid_i,
    output pli_pkg::seq_state_t state_o,
    output logic                take_o,
    output logic [CH_W-1:0]     chan_o
);
    import pli_pkg::*;

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    seq_state_t      state_q;
    seq_state_t      state_d;
    logic [CH_W-1:0] chan_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_WAIT: if (sync_i) state_d = SEQ_RUN;
            SEQ_RUN:  state_d = SEQ_RUN;
        endcase
    end

    // outputs
    always_comb begin
        take_o = 1'b0;
        chan_o = sync_i ? '0 : chan_cnt;
        unique case (state_q)
            SEQ_WAIT: take_o = valid_i && sync_i;
            SEQ_RUN:  take_o = valid_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_cnt <= '0;
        end else if (take_o) begin
            chan_cnt <= (chan_o == LAST_CH) ? '0 : chan_o + 1'b1;
        end else if (sync_i) begin
            chan_cnt <= '0;
        end
    end

    assign state_o = state_q;

    // R5
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_cnt) < NCH);

    // R5
    chan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !sync_i) |=> $stable(chan_cnt));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && !sync_i) |=> (state_q == SEQ_WAIT && chan_cnt == '0));

endmodule

// File: rtl/pli_step_accum.sv
module pli_step_accum #(
    parameter int NCH    = 256,
    parameter int ACC_W  = 31,
    parameter int STEP_W = 17,
    parameter int OFS_W  = 10,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              upd_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [OFS_W-1:0]  acc_top_o
);
    logic [ACC_W-1:0] acc_mem [NCH];
    logic [NCH-1:0]   live;
    logic [ACC_W-1:0] acc_cur;
    logic [ACC_W-1:0] acc_sum;

    // a channel not touched since the last flush reads as zero
    always_comb begin
        if (flush_i || !live[ch_i]) begin
            acc_cur = '0;
        end else begin
            acc_cur = acc_mem[ch_i];
        end
        acc_sum = acc_cur + {{(ACC_W-STEP_W){1'b0}}, step_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else begin
            if (flush_i) begin
                live <= '0;
            end
            if (upd_i) begin
                live[ch_i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_i) begin
            acc_mem[ch_i] <= acc_sum;
        end
    end

    assign acc_top_o = acc_cur[ACC_W-1 -: OFS_W];

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> ($countones(live) <= 1));

    // R4
    upd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> live[$past(ch_i)]);

endmodule

// File: rtl/phase_index_gen.sv
module phase_index_gen #(
    parameter int NCH    = 256,
    parameter int OFS_W  = 10,
    parameter int STEP_W = 17,
    parameter int ACC_W  = 31,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CFG_W = (STEP_W > OFS_W) ? STEP_W : OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             smp_valid,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CH_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             idx_valid,
    output logic [CH_W-1:0]  idx_chan,
    output logic [OFS_W-1:0] idx_value
);
    import pli_pkg::*;

    seq_state_t        seq_state;
    logic              take;
    logic [CH_W-1:0]   cur_ch;
    logic [OFS_W-1:0]  cur_ofs;
    logic [STEP_W-1:0] cur_step;
    logic [OFS_W-1:0]  acc_top;
    logic [OFS_W-1:0]  idx_next;

    pli_chan_seq #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_in),
        .valid_i (smp_valid),
        .state_o (seq_state),
        .take_o  (take),
        .chan_o  (cur_ch)
    );

    pli_coef_store #(
        .NCH    (NCH),
        .OFS_W  (OFS_W),
        .STEP_W (STEP_W),
        .CFG_W  (CFG_W),
        .CH_W   (CH_W)
    ) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_i    (sync_in),
        .wr_en_i   (cfg_wr),
        .wr_sel_i  (cfg_sel),
        .wr_addr_i (cfg_addr),
        .wr_data_i (cfg_data),
        .rd_addr_i (cur_ch),
        .rd_ofs_o  (cur_ofs),
        .rd_step_o (cur_step)
    );

    pli_step_accum #(
        .NCH    (NCH),
        .ACC_W  (ACC_W),
        .STEP_W (STEP_W),
        .OFS_W  (OFS_W),
        .CH_W   (CH_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (sync_in),
        .upd_i     (take),
        .ch_i      (cur_ch),
        .step_i    (cur_step),
        .acc_top_o (acc_top)
    );

    // modulo 2^OFS_W by truncation
    assign idx_next = cur_ofs + acc_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_valid <= 1'b0;
            idx_chan  <= '0;
            idx_value <= '0;
        end else begin
            idx_valid <= take;
            if (take) begin
                idx_chan  <= cur_ch;
                idx_value <= idx_next;
            end
        end
    end

    // R2
    wait_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_WAIT && !sync_in) |=> !idx_valid);

    // R9
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !idx_valid);

    // R5
    sync_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && smp_valid) |=> (idx_valid && idx_chan == '0));

endmodule

// File: tb/phase_index_gen_test.sv
module phase_index_gen_test;

    localparam int NCH    = 4;
    localparam int OFS_W  = 10;
    localparam int STEP_W = 17;
    localparam int ACC_W  = 31;
    localparam int CH_W   = 2;
    localparam int CFG_W  = 17;
    localparam longint ACC_MASK = (64'd1 << ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_in = 1'b0;
    logic             smp_valid = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [CH_W-1:0]  cfg_addr = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic             idx_valid;
    logic [CH_W-1:0]  idx_chan;
    logic [OFS_W-1:0] idx_value;

    always #4 clk = ~clk;

    phase_index_gen #(
        .NCH    (NCH),
        .OFS_W  (OFS_W),
        .STEP_W (STEP_W),
        .ACC_W  (ACC_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .smp_valid (smp_valid),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .idx_valid (idx_valid),
        .idx_chan  (idx_chan),
        .idx_value (idx_value)
    );

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // behavioural model
    int     m_ofs [2][NCH];
    int     m_stp [2][NCH];
    longint m_acc [NCH];
    int     m_act = 0;
    bit     m_run = 0;
    int     m_ch = 0;
    bit     e_v = 0;
    int     e_ch = 0;
    int     e_ix = 0;

    task automatic compare();
        checks++;
        if (idx_valid !== e_v || (e_v && (int'(idx_chan) != e_ch || int'(idx_value) != e_ix))) begin
            failures++;
            $display("FAIL %s: actual v=%0b ch=%0d ix=%0d expected v=%0b ch=%0d ix=%0d",
                     tag, idx_valid, idx_chan, idx_value, e_v, e_ch, e_ix);
        end
    endtask

    task automatic cyc(input bit s, input bit v, input bit w, input bit sel,
                       input int addr, input int data);
        @(negedge clk);
        compare();
        sync_in   = s;
        smp_valid = v;
        cfg_wr    = w;
        cfg_sel   = sel;
        cfg_addr  = CH_W'(addr);
        cfg_data  = CFG_W'(data);
        e_v = 0;
        if (s) begin
            m_act = 1 - m_act;
            for (int c = 0; c < NCH; c++) m_acc[c] = 0;
            m_ch  = 0;
            m_run = 1;
        end
        if (v && m_run) begin
            e_v  = 1;
            e_ch = m_ch;
            e_ix = (m_ofs[m_act][m_ch] + int'(m_acc[m_ch] >> (ACC_W - OFS_W))) % (1 << OFS_W);
            m_acc[m_ch] = (m_acc[m_ch] + longint'(m_stp[m_act][m_ch])) & ACC_MASK;
            m_ch = (m_ch + 1) % NCH;
        end
        if (w) begin
            if (sel) m_stp[1 - m_act][addr] = data % (1 << STEP_W);
            else     m_ofs[1 - m_act][addr] = data % (1 << OFS_W);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) cyc(0, (gap == 0) || (i % gap != 0), 0, 0, 0, 0);
    endtask

    // fill the inactive page while samples keep flowing
    task automatic fill(input int o0, input int o1, input int o2, input int o3,
                        input int s0, input int s1, input int s2, input int s3);
        int ov[4];
        int sv[4];
        ov = '{o0, o1, o2, o3};
        sv = '{s0, s1, s2, s3};
        for (int c = 0; c < NCH; c++) begin
            cyc(0, 1, 1, 0, c, ov[c]);
            cyc(0, 1, 1, 1, c, sv[c]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R3: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_acc[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no output after reset
        tag = "R1";
        idle(3);
        // R2: samples before the first sync are dropped; page 1 filled meanwhile
        tag = "R2";
        fill(5, 1000, 512, 0, 131071, 65536, 1, 0);
        run(10, 0);
        // R6: sample together with sync is t=0 of channel 0
        tag = "R6";
        cyc(1, 1, 0, 0, 0, 0);
        // R3, R4: bare offset first, then accumulation, with gaps
        tag = "R3";
        run(40, 0);
        run(2000, 5);
        // R7: writes to the inactive page do not disturb current output
        tag = "R7";
        fill(7, 20, 1023, 300, 1000, 2, 131071, 4096);
        run(300, 3);
        // R9: idle cycles produce no output
        tag = "R9";
        idle(5);
        // R7: sync without sample makes new page active
        tag = "R7";
        cyc(1, 0, 0, 0, 0, 0);
        run(800, 0);
        // R5: channel counter restarts on mid-stream sync
        tag = "R5";
        run(3, 0);
        cyc(1, 1, 0, 0, 0, 0);
        run(9, 2);
        // R8: write in the sync cycle goes to page inactive after swap
        tag = "R8";
        cyc(1, 1, 1, 0, 2, 77);
        fill(11, 22, 33, 44, 131071, 131071, 131071, 131071);
        cyc(1, 1, 1, 1, 1, 9);
        run(50, 0);
        cyc(1, 1, 0, 0, 0, 0);
        run(50, 0);
        // R4: long interval wraps the accumulator modulo 2^ACC_W
        tag = "R4";
        fill(0, 999, 1, 600, 131071, 131071, 131071, 130000);
        cyc(1, 1, 0, 0, 0, 0);
        run(70000, 0);
        tag = "R3";
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule